// File: doc/BRIEF.md
# Transposition Mesh Router with Parity Collection

This block routes single-bit packets across a small square grid of cells using only neighbour-to-neighbour compare-exchange steps. Each cell holds at most one packet, which names a destination cell by row and column. The pairing of neighbours is not chosen per packet. It follows a fixed four-step rotation: horizontal pairs that start on an even column, then vertical pairs that start on an even row, then horizontal pairs that start on an odd column, then vertical pairs that start on an odd row.

A packet that sits in its own destination cell is absorbed. Absorbing it flips a parity bit kept for that cell. When two packets bound for the same cell meet in one pair, both are dropped, because together they add nothing modulo 2. When routing ends, each cell's parity bit is the sum over GF(2) of the packets that were addressed to it. This is the accumulate step of a sparse binary matrix-vector product.

The whole grid is written at once through a wide load port. The result is read from a parallel parity port once the done flag is high.

Top module: `cwt_mesh_router`

## Requirements
- R1: A cycle with `load` high writes every cell from `load_pkts`, clears all parity bits, puts the phase back to 0 and drops `done`. Each of these takes effect at the next clock edge, and a load in the middle of a run discards the packets still in flight. Cell (r,c) occupies the slice at index (r*M+c)*PW, where PW = 1+2*log2(M). The packet layout is: valid bit at the top, destination row in the middle field, destination column in the low field.
- R2: The `phase` output takes values 0 to 3 and advances by one, wrapping, at every edge without a load. The encoding is 0 = horizontal pairs from even columns, 1 = vertical pairs from even rows, 2 = horizontal pairs from odd columns, 3 = vertical pairs from odd rows.
- R3: On each edge only the pairs of the current phase exchange contents. Cells that have no partner in that phase keep their packet. A lone packet moves one cell toward its destination along the phase's axis when its pair allows it.
- R4: When both cells of a pair hold packets, the packet with the larger distance to go along the phase's axis decides whether they swap. It votes to swap when the swap brings it closer. On equal distances, the packet in the lower-index cell decides.
- R5: Two packets with the same destination that meet in one pair are both removed. The parity bits do not change.
- R6: A packet sitting in its own destination cell at a clock edge is removed at that edge, and that cell's parity bit toggles.
- R7: Once the grid is empty, parity bit r*M+c equals the number of loaded valid packets addressed to (r,c), modulo 2.
- R8: After reset the parity bits are 0, `done` is 1 and `phase` is 0. On every edge without a load, `done` becomes 1 exactly when no packet is left after that edge.
- R9: Packets are never created. While `done` is high and no load arrives, the parity bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Replace the grid contents with `load_pkts` |
| load_pkts | input | M*M*(1+2*log2(M)) | One packet per cell: valid, destination row, destination column |
| parity | output | M*M | Per-cell parity of absorbed packets, bit r*M+c |
| done | output | 1 | High when no packet remains in the grid |
| phase | output | 2 | Pairing phase that the next edge will apply |

## Verification
The checker assumes that `load` is the only way packets enter and that `rst` is asserted from time zero. Between loads it therefore expects the packet count plus the number of parity flips in a cycle never to exceed the previous packet count, and it expects nothing to move once the grid is empty. The bench drives `load` for one cycle only, while `rst` is low, and never touches `load_pkts` in a way the design could see except in that cycle. Its randomised loads fill only part of the grid, and the dense cases are built so that packets start on or next to their destinations. This keeps every run inside a bounded routing time.

// File: rtl/cwt_mesh_pkg.sv
package cwt_mesh_pkg;

  typedef enum logic [1:0] {
    PH_H_EVEN = 2'd0,
    PH_V_EVEN = 2'd1,
    PH_H_ODD  = 2'd2,
    PH_V_ODD  = 2'd3
  } phase_e;

endpackage

// File: rtl/cwt_phase_seq.sv
module cwt_phase_seq
  import cwt_mesh_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   restart,
  output phase_e phase
);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= PH_H_EVEN;
    end else begin
      phase <= phase_e'(phase + 2'd1);
    end
  end

endmodule

// File: rtl/cwt_cx_pair.sv
module cwt_cx_pair #(
  parameter int AW   = 2,
  parameter bit VERT = 1'b0,
  parameter int LO   = 0,
  localparam int PW  = 1 + 2 * AW
) (
  input  logic [PW-1:0] lo_pkt,
  input  logic [PW-1:0] hi_pkt,
  output logic [PW-1:0] lo_out,
  output logic [PW-1:0] hi_out
);

  localparam logic [AW:0] LO_P = (AW + 1)'(LO);
  localparam logic [AW:0] HI_P = (AW + 1)'(LO + 1);

  logic          v_lo, v_hi;
  logic [AW:0]   k_lo, k_hi;
  logic [AW:0]   d_lo, d_hi;
  logic          want_lo, want_hi;
  logic          cancel, swap;

  always_comb begin
    v_lo = lo_pkt[PW-1];
    v_hi = hi_pkt[PW-1];
    k_lo = VERT ? {1'b0, lo_pkt[2*AW-1:AW]} : {1'b0, lo_pkt[AW-1:0]};
    k_hi = VERT ? {1'b0, hi_pkt[2*AW-1:AW]} : {1'b0, hi_pkt[AW-1:0]};

    d_lo = (k_lo > LO_P) ? (k_lo - LO_P) : (LO_P - k_lo);
    d_hi = (k_hi > HI_P) ? (k_hi - HI_P) : (HI_P - k_hi);

    want_lo = v_lo && (k_lo > LO_P);
    want_hi = v_hi && (k_hi < HI_P);

    cancel = v_lo && v_hi && (lo_pkt[2*AW-1:0] == hi_pkt[2*AW-1:0]);

    if (v_lo && v_hi) begin
      swap = (d_lo >= d_hi) ? want_lo : want_hi;
    end else begin
      swap = want_lo || want_hi;
    end

    if (cancel) begin
      lo_out = '0;
      hi_out = '0;
    end else if (swap) begin
      lo_out = hi_pkt;
      hi_out = lo_pkt;
    end else begin
      lo_out = lo_pkt;
      hi_out = hi_pkt;
    end
  end

endmodule

// File: rtl/cwt_absorb.sv
module cwt_absorb #(
  parameter int AW  = 2,
  parameter int ROW = 0,
  parameter int COL = 0,
  localparam int PW = 1 + 2 * AW
) (
  input  logic [PW-1:0] pkt_in,
  output logic [PW-1:0] pkt_out,
  output logic          hit
);

  always_comb begin
    hit = pkt_in[PW-1]
        && (pkt_in[2*AW-1:AW] == AW'(ROW))
        && (pkt_in[AW-1:0] == AW'(COL));
    pkt_out = hit ? '0 : pkt_in;
  end

endmodule

// File: rtl/cwt_mesh_router.sv
module cwt_mesh_router
  import cwt_mesh_pkg::*;
#(
  parameter int M   = 4,
  localparam int AW = (M > 1) ? $clog2(M) : 1,
  localparam int PW = 1 + 2 * AW,
  localparam int N  = M * M
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [N*PW-1:0] load_pkts,
  output logic [N-1:0]  parity,
  output logic          done,
  output logic [1:0]    phase
);

  logic [PW-1:0] cell_q    [N];
  logic [PW-1:0] after_abs [N];
  logic [PW-1:0] res       [4][N];
  logic [PW-1:0] nxt       [N];
  logic [N-1:0]  hit;
  logic [N-1:0]  cell_valid;
  logic [N-1:0]  nxt_valid;
  phase_e        ph;

  cwt_phase_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .phase   (ph)
  );

  assign phase = ph;

  // Absorption of packets already at their destination cell
  for (genvar i = 0; i < N; i++) begin : g_abs
    cwt_absorb #(.AW(AW), .ROW(i / M), .COL(i % M)) u_abs (
      .pkt_in  (cell_q[i]),
      .pkt_out (after_abs[i]),
      .hit     (hit[i])
    );
    assign cell_valid[i] = cell_q[i][PW-1];
  end

  // One set of compare-exchange pairs per phase of the schedule
  for (genvar p = 0; p < 4; p++) begin : g_ph
    for (genvar i = 0; i < N; i++) begin : g_cell
      localparam int  R      = i / M;
      localparam int  C      = i % M;
      localparam bit  VRT    = (p % 2) == 1;
      localparam int  OFF    = p / 2;
      localparam int  POS    = VRT ? R : C;
      localparam int  STRIDE = VRT ? M : 1;
      localparam bit  IS_LO  = ((POS % 2) == OFF) && (POS + 1 < M);
      localparam bit  IS_HI  = (POS >= 1) && (((POS - 1) % 2) == OFF);
      if (IS_LO) begin : g_pair
        cwt_cx_pair #(.AW(AW), .VERT(VRT), .LO(POS)) u_cx (
          .lo_pkt (after_abs[i]),
          .hi_pkt (after_abs[i+STRIDE]),
          .lo_out (res[p][i]),
          .hi_out (res[p][i+STRIDE])
        );
      end else if (!IS_HI) begin : g_idle
        assign res[p][i] = after_abs[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      nxt[i]       = res[ph][i];
      nxt_valid[i] = nxt[i][PW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) cell_q[i] <= '0;
      parity <= '0;
      done   <= 1'b1;
    end else if (load) begin
      for (int i = 0; i < N; i++) cell_q[i] <= load_pkts[i*PW +: PW];
      parity <= '0;
      done   <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) cell_q[i] <= nxt[i];
      parity <= parity ^ hit;
      done   <= ~|nxt_valid;
    end
  end

endmodule

// File: rtl/cwt_mesh_checker.sv
module cwt_mesh_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [1:0]   phase,
  input logic         done,
  input logic [N-1:0] parity,
  input logic [N-1:0] cell_valid
);

  // R2: rotation through the four pairing phases
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> (phase == 2'($past(phase) + 2'd1)));

  // R1: a load restarts the schedule and clears results
  p_load_restart_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == 2'd0 && parity == '0 && !done));

  // R9: nothing moves once the grid is empty
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(parity)));

  // R9: packets are never created between loads
  p_no_creation_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($countones(cell_valid) <= $past($countones(cell_valid))));

  // R6: each parity flip consumes one packet
  p_absorb_account_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($countones(cell_valid) + $countones(parity ^ $past(parity))
               <= $past($countones(cell_valid))));

endmodule

bind cwt_mesh_router cwt_mesh_checker #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .phase      (phase),
  .done       (done),
  .parity     (parity),
  .cell_valid (cell_valid)
);

// File: tb/cwt_mesh_router_bench.sv
module cwt_mesh_router_bench;
  localparam int M  = 4;
  localparam int AW = 2;
  localparam int PW = 1 + 2 * AW;
  localparam int N  = M * M;
  localparam int NT = 6;

  // stimulus table: {xorshift seed, occupancy mask}
  localparam logic [47:0] VEC [NT] = '{
    48'h9E3779B9_A5A5, 48'h7F4A7C15_1111, 48'hC2B2AE35_8421,
    48'h27D4EB2F_F00F, 48'h165667B1_3C3C, 48'hD3A2646C_6DB6
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            load = 1'b0;
  logic [N*PW-1:0] load_pkts = '0;
  logic [N-1:0]    parity;
  logic            done;
  logic [1:0]      phase;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cwt_mesh_router #(.M(M)) u_cwt_mesh_router (
    .clk(clk), .rst(rst), .load(load), .load_pkts(load_pkts),
    .parity(parity), .done(done), .phase(phase)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*PW-1:0] put(logic [N*PW-1:0] v, int r, int c, int dr, int dc);
    v[(r*M+c)*PW +: PW] = {1'b1, AW'(dr), AW'(dc)};
    return v;
  endfunction

  function automatic logic [N-1:0] ref_par(logic [N*PW-1:0] v);
    logic [N-1:0] p = '0;
    for (int i = 0; i < N; i++) begin
      logic [PW-1:0] k = v[i*PW +: PW];
      if (k[PW-1]) p[k[2*AW-1:AW]*M + k[AW-1:0]] ^= 1'b1;
    end
    return p;
  endfunction

  function automatic logic [N*PW-1:0] expand(logic [47:0] e);
    logic [N*PW-1:0] v = '0;
    logic [31:0] s = e[47:16];
    for (int i = 0; i < N; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      if (e[i]) v = put(v, i / M, i % M, int'(s[1:0]), int'(s[3:2]));
    end
    return v;
  endfunction

  task automatic do_load(logic [N*PW-1:0] v);
    @(negedge clk);
    load_pkts = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N*PW-1:0] v;
    step(3);
    rst = 1'b0;
    // R8: reset state
    chk("R8", "parity", 32'(parity), 32'h0);
    chk("R8", "done",   32'(done),   32'h1);
    chk("R8", "phase",  32'(phase),  32'h0);

    // R2: phase sequence after a load, R1: load drops done
    do_load(put('0, 0, 0, 3, 3));
    chk("R1", "done after load", 32'(done), 32'h0);
    chk("R2", "phase 0", 32'(phase), 32'h0);
    for (int k = 1; k <= 4; k++) begin
      step(1);
      chk("R2", "phase step", 32'(phase), 32'(k % 4));
    end

    // R3: lone packet crosses one even horizontal pair
    do_load(put('0, 0, 0, 0, 1));
    step(1);
    chk("R3", "pending parity", 32'(parity), 32'h0);
    chk("R3", "pending done",   32'(done),   32'h0);
    step(1);
    chk("R3", "arrival parity", 32'(parity), 32'h0002);
    chk("R8", "done on empty",  32'(done),   32'h1);

    // R3: move waits for the odd horizontal phase
    do_load(put('0, 0, 1, 0, 2));
    step(3);
    chk("R3", "waiting parity", 32'(parity), 32'h0);
    step(1);
    chk("R3", "odd phase move", 32'(parity), 32'h0004);

    // R4: farther packet wants swap
    v = put('0, 0, 0, 3, 0);
    v = put(v, 0, 1, 0, 0);
    do_load(v);
    step(2);
    chk("R4", "farther swaps", 32'(parity), 32'h0001);

    // R4: farther packet refuses swap
    v = put('0, 0, 2, 0, 0);
    v = put(v, 0, 3, 0, 2);
    do_load(v);
    step(2);
    chk("R4", "farther keeps", 32'(parity), 32'h0);
    step(4);
    chk("R4", "both arrive", 32'(parity), 32'h0005);
    chk("R4", "done", 32'(done), 32'h1);

    // R5: same-target pair annihilates
    v = put('0, 0, 0, 2, 2);
    v = put(v, 0, 1, 2, 2);
    do_load(v);
    step(1);
    chk("R5", "done", 32'(done), 32'h1);
    chk("R5", "parity", 32'(parity), 32'h0);

    // R6: every packet starts on its target
    v = '0;
    for (int i = 0; i < N; i++) v = put(v, i / M, i % M, i / M, i % M);
    do_load(v);
    step(1);
    chk("R6", "full absorb", 32'(parity), 32'hFFFF);
    chk("R6", "done", 32'(done), 32'h1);

    // R9: idle grid holds its result
    step(8);
    chk("R9", "parity held", 32'(parity), 32'hFFFF);
    chk("R9", "done held", 32'(done), 32'h1);

    // R1: load clears parity even while results are shown
    do_load(put('0, 1, 2, 1, 2));
    chk("R1", "parity cleared", 32'(parity), 32'h0);
    step(1);
    chk("R6", "single absorb", 32'(parity), 32'h0040);

    // R7: table of randomised loads against the reference parity
    for (int t = 0; t < NT; t++) begin
      int n = 0;
      v = expand(VEC[t]);
      do_load(v);
      while (!done && n < 400) begin
        step(1);
        n++;
      end
      chk("R7", "finished", 32'(done), 32'h1);
      chk("R7", "parity", 32'(parity), 32'(ref_par(v)));
    end

    // R1: reload in the middle of a run discards packets in flight
    do_load(expand(VEC[5]));
    step(2);
    do_load(put('0, 2, 3, 2, 3));
    chk("R1", "reload parity", 32'(parity), 32'h0);
    chk("R1", "reload done", 32'(done), 32'h0);
    step(1);
    chk("R1", "reload result", 32'(parity), 32'h0800);
    chk("R1", "reload empty", 32'(done), 32'h1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule